// File: doc/BRIEF.md
# Pin Event Status and Mask Unit

This block watches a parameterised bank of input pins (128 by default) and turns activity on them into interrupt requests. Each pin carries a two-bit detection mode, supplied by the pad configuration logic outside this block. The mode chooses between rising-edge detection, active-high level detection and no detection. Detected events are held in per-pin sticky status bits. A per-pin enable bit masks each one, and a single shared interrupt line is raised whenever any pending status bit has its enable bit set.

Software sees the status and enable bits as 32-bit words on a simple register bus, 32 pins per word. A status bit is acknowledged by writing a zero to it. Writing a one leaves it alone, so reading a word, clearing one bit and writing the word back acknowledges a single pin without losing events on the others. Pin level inputs must already be synchronised to the block clock. Priority encoding, vectoring and storage of the pad configuration are handled elsewhere.

Top module: `gpio_irq_unit`

## Requirements
- R1: Status word w is at byte address 0x20 + 8*w and enable word w is at 0x24 + 8*w. Pin p sits in word p/32 at bit p%32. A read of any other address returns zero.
- R2: With mode code 1, a pin sampled high in a cycle after being sampled low in the previous cycle sets its status bit at that clock edge. A falling transition sets nothing.
- R3: With mode code 0, the status bit is set at every clock edge where the pin is sampled high, and it stays set after the pin goes low.
- R4: With mode code 2 or mode code 3, the pin never sets its status bit, whatever its level does.
- R5: A bus write to a status word clears exactly the bits written as 0. Bits written as 1 keep their value.
- R6: When an event and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R7: In mode 0, clearing a bit while the pin is still high has no lasting effect. Once the pin is low, a clear removes the bit.
- R8: The interrupt output is a register and is high one cycle after any status bit and its enable bit are both set. A pending bit whose enable is 0 stays pending and does not raise the output.
- R9: An enable word takes the written value and reads it back unchanged. Writing an enable word does not change any status bit.
- R10: While reset is high and after it is released, all status and enable bits read zero and the interrupt output is low.
- R11: Read data is registered. It appears on the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | NUM_PINS | Synchronised pin levels |
| pin_mode | input | 2*NUM_PINS | Detection mode per pin; pin p uses bits [2p+1:2p] |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Registered read data |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The assertions assume that pin levels and mode codes are stable, synchronous values sampled only at the clock edge. They also assume that read and write strobes are never raised in the same cycle. An event seen at an edge is assumed to be the only way a status bit can rise. The bench drives every input half a period away from the rising edge. It never raises both strobes together, and it returns all pins low with detection disabled before each table row, so no leftover edge history from a previous row leaks into the next one.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL_HI = 2'd0,
    MODE_RISE     = 2'd1,
    MODE_OFF      = 2'd2,
    MODE_SPARE    = 2'd3
  } det_mode_t;

  localparam int STAT_BASE  = 32'h20;
  localparam int EN_BASE    = 32'h24;
  localparam int WORD_PITCH = 8;

  function automatic int stat_addr(input int w);
    return STAT_BASE + w * WORD_PITCH;
  endfunction

  function automatic int en_addr(input int w);
    return EN_BASE + w * WORD_PITCH;
  endfunction
endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 128
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   pin_lvl,
  input  logic [2*NUM_PINS-1:0] pin_mode,
  output logic [NUM_PINS-1:0]   evt
);
  logic [NUM_PINS-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= pin_lvl;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    det_mode_t m;
    assign m = det_mode_t'(pin_mode[2*i +: 2]);
    always_comb begin
      unique case (m)
        MODE_LEVEL_HI: evt[i] = pin_lvl[i];
        MODE_RISE:     evt[i] = pin_lvl[i] & ~lvl_q[i];
        default:       evt[i] = 1'b0;
      endcase
    end

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
      pin_mode[2*i+1] |-> !evt[i]); // R4
  end

  AST_NO_FALL_EVT: assert property (@(posedge clk) disable iff (rst)
    ((evt & lvl_q & ~pin_lvl) == '0)); // R2
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
  import gpio_irq_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  localparam int PAD_W    = NUM_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAD_W-1:0]  evt,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [PAD_W-1:0]  status,
  output logic [PAD_W-1:0]  enable
);
  logic [PAD_W-1:0] clr_mask;
  logic [PAD_W-1:0] status_d;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit_st, hit_en;
    assign hit_st = bus_wr && (bus_addr == ADDR_W'(stat_addr(w)));
    assign hit_en = bus_wr && (bus_addr == ADDR_W'(en_addr(w)));
    assign clr_mask[w*WORD_W +: WORD_W] = hit_st ? ~bus_wdata : '0;

    always_ff @(posedge clk) begin
      if (rst)         enable[w*WORD_W +: WORD_W] <= '0;
      else if (hit_en) enable[w*WORD_W +: WORD_W] <= bus_wdata;
    end
  end

  assign status_d = (status & ~clr_mask) | evt;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= status_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt))); // R6
  AST_RISE_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(evt)) == '0)); // R2
  AST_WR1_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr) |=> ((status & $past(status)) == $past(status))); // R5
endmodule

// File: rtl/gpio_irq_rdmux.sv
module gpio_irq_rdmux
  import gpio_irq_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  localparam int PAD_W    = NUM_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PAD_W-1:0]  status,
  input  logic [PAD_W-1:0]  enable,
  output logic [WORD_W-1:0] bus_rdata
);
  logic [WORD_W-1:0] rd_next;
  logic              mapped;

  always_comb begin
    rd_next = '0;
    mapped  = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (bus_addr == ADDR_W'(stat_addr(w))) begin
        rd_next = status[w*WORD_W +: WORD_W];
        mapped  = 1'b1;
      end
      if (bus_addr == ADDR_W'(en_addr(w))) begin
        rd_next = enable[w*WORD_W +: WORD_W];
        mapped  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !mapped) |=> (bus_rdata == '0)); // R1
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd) |=> $stable(bus_rdata)); // R11
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 128,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 8,
  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int PAD_W     = NUM_WORDS * WORD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   pin_lvl,
  input  logic [2*NUM_PINS-1:0] pin_mode,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  output logic [WORD_W-1:0]     bus_rdata,
  output logic                  irq_o
);
  logic [NUM_PINS-1:0] evt;
  logic [PAD_W-1:0]    evt_pad;
  logic [PAD_W-1:0]    status;
  logic [PAD_W-1:0]    enable;

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .pin_mode(pin_mode), .evt(evt)
  );

  for (genvar i = 0; i < PAD_W; i++) begin : g_pad
    if (i < NUM_PINS) begin : g_real
      assign evt_pad[i] = evt[i];
    end else begin : g_tie
      assign evt_pad[i] = 1'b0;
    end
  end

  gpio_irq_status #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_st (
    .clk(clk), .rst(rst), .evt(evt_pad), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .status(status), .enable(enable)
  );

  gpio_irq_rdmux #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .status(status), .enable(enable), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status & enable);
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(enable) != '0)); // R8
  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(status) != '0)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && status == '0 && enable == '0)); // R10
endmodule

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;
  localparam int NP = 128;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0]   pin_lvl;
  logic [2*NP-1:0] pin_mode;
  logic          bus_wr, bus_rd;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_unit u0 (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .pin_mode(pin_mode),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // row: pin[13:7] mode[6:5] en[4] lvl_a[3] lvl_b[2] exp_stat[1] exp_irq[0]
  localparam logic [13:0] VEC [NV] = '{
    {7'd5,   2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {7'd40,  2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {7'd70,  2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {7'd127, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {7'd96,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {7'd33,  2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {7'd64,  2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {7'd0,   2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'd31,  2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {7'd100, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  function automatic logic [7:0] sa(input int w); return 8'(32'h20 + 8*w); endfunction
  function automatic logic [7:0] ea(input int w); return 8'(32'h24 + 8*w); endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  // R11: data is taken after the edge that follows the strobe
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic clean();
    pin_lvl  = '0;
    pin_mode = {NP{2'b10}};
    tick(); tick();
    for (int w = 0; w < 4; w++) begin
      wr(sa(w), 32'h0);
      wr(ea(w), 32'h0);
    end
    tick();
  endtask

  task automatic set_mode(input int p, input logic [1:0] m);
    pin_mode[2*p +: 2] = m;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_lvl = '0; pin_mode = {NP{2'b10}};
    tick(); tick();
    chk("R10 irq in reset", {31'd0, irq_o}, 32'd0);
    tick(); rst = 1'b0; tick();
    chk("R10 irq after reset", {31'd0, irq_o}, 32'd0);
    rd(sa(0), d); chk("R10 status word 0", d, 32'd0);
    rd(ea(3), d); chk("R10 enable word 3", d, 32'd0);
    wr(ea(1), 32'hA5A5_0F0F);
    rd(8'h00, d); chk("R1 unmapped read", d, 32'd0);
    tick();
    chk("R11 read data holds", bus_rdata, 32'd0);
    rd(ea(1), d); chk("R9 enable readback", d, 32'hA5A5_0F0F);
    rd(sa(1), d); chk("R9 enable write leaves status", d, 32'd0);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      int p;
      logic [1:0] m;
      logic [31:0] bitv;
      p = int'(VEC[v][13:7]);
      m = VEC[v][6:5];
      bitv = 32'd1 << (p % 32);
      clean();
      set_mode(p, m);
      wr(ea(p / 32), VEC[v][4] ? bitv : 32'd0);
      pin_lvl[p] = VEC[v][3]; tick();
      pin_lvl[p] = VEC[v][2]; tick();
      pin_lvl[p] = 1'b0; tick(); tick();
      chk($sformatf("R8 irq row %0d", v), {31'd0, irq_o}, {31'd0, VEC[v][0]});
      rd(sa(p / 32), d);
      // R1 R2 R3 R4 outcome of each row lands at word p/32 bit p%32
      chk($sformatf("R2/R3/R4 status row %0d", v), d, VEC[v][1] ? bitv : 32'd0);
    end

    // R5: acknowledge one pin, other stays
    clean();
    set_mode(3, 2'd1); set_mode(9, 2'd1);
    pin_lvl[3] = 1'b1; pin_lvl[9] = 1'b1; tick();
    pin_lvl[3] = 1'b0; pin_lvl[9] = 1'b0; tick();
    rd(sa(0), d); chk("R5 both pending", d, 32'h0000_0208);
    wr(sa(0), ~32'h0000_0008);
    rd(sa(0), d); chk("R5 only zero bit cleared", d, 32'h0000_0200);

    // R6: edge and clear at the same edge
    clean();
    set_mode(12, 2'd1);
    tick();
    pin_lvl[12] = 1'b1;
    wr(sa(0), 32'h0);
    pin_lvl[12] = 1'b0;
    rd(sa(0), d); chk("R6 set wins over clear", d, 32'h0000_1000);

    // R7: level pin still high
    clean();
    set_mode(50, 2'd0);
    pin_lvl[50] = 1'b1; tick(); tick();
    wr(sa(1), 32'h0);
    rd(sa(1), d); chk("R7 clear while high", d, 32'h0004_0000);
    pin_lvl[50] = 1'b0; tick();
    wr(sa(1), 32'h0);
    rd(sa(1), d); chk("R7 clear after low", d, 32'h0);

    // R8/R9: masked pending, then unmask, then acknowledge
    clean();
    set_mode(20, 2'd1);
    pin_lvl[20] = 1'b1; tick(); pin_lvl[20] = 1'b0; tick(); tick();
    chk("R8 masked no irq", {31'd0, irq_o}, 32'd0);
    wr(ea(0), 32'h0010_0000);
    tick();
    chk("R8 unmask raises irq", {31'd0, irq_o}, 32'd1);
    rd(sa(0), d); chk("R9 status kept across enable write", d, 32'h0010_0000);
    wr(sa(0), 32'h0);
    tick();
    chk("R8 irq drops after clear", {31'd0, irq_o}, 32'd0);

    // R2: falling transition in edge mode
    clean();
    pin_lvl[7] = 1'b1; tick(); tick();
    set_mode(7, 2'd1); tick();
    pin_lvl[7] = 1'b0; tick(); tick();
    rd(sa(0), d); chk("R2 falling edge ignored", d, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule